// File: doc/BRIEF.md
# Interrupt Opcode Injection Unit

This unit sits in the instruction-fetch path of a small microcoded 8-bit processor. It turns an external interrupt request into a forced subroutine call. The request pin passes through a two-flop synchroniser. On each opcode-fetch edge the unit decides what to load into the opcode register. If a synchronised request is present and interrupts are not masked, a multiplexer selects a fixed, hardwired interrupt opcode instead of the byte on the memory data bus. The fetched instruction is thereby discarded. On that same edge the mask bit is set and a one-cycle acknowledge pulse is issued.

The microcode that runs the injected opcode is an indirect call through a fixed vector address held in writable memory. A small sequencer stub stands in for it and has four named states. `ST_RUN` is normal execution, and the only state in which fetches are accepted. `ST_SAVE` is one cycle that saves the return point. `ST_VEC_LO` reads the vector's low byte at the vector address. `ST_VEC_HI` reads the high byte at the vector address plus one. The transitions are fixed:
- `ST_RUN` goes to `ST_SAVE` on a taken interrupt.
- `ST_SAVE` goes to `ST_VEC_LO`.
- `ST_VEC_LO` goes to `ST_VEC_HI`.
- `ST_VEC_HI` goes back to `ST_RUN`.

The handler finishes with a return strobe, which clears the mask. The request is level-sensitive. A line that is still high after the return is taken again at the next fetch.

Top module: `irq_inject_unit`

## Requirements
- R1: After reset the opcode register reads 8'h00, the mask output is 1, the acknowledge output is 0 and the sequencer is idle (busy 0).
- R2: A fetch strobe in `ST_RUN` that does not take an interrupt loads the data bus into the opcode register, visible the cycle after the edge. Without a fetch strobe, the opcode register holds its value.
- R3: A fetch edge that sees a synchronised request while unmasked loads `IRQ_OPCODE` (default 8'h00) instead of the data bus.
- R4: The mask is set on the same edge that injects the opcode. The acknowledge output is then high for exactly one cycle.
- R5: While masked, a high request has no effect. Fetches load the data bus and no acknowledge is given.
- R6: The request is seen only through two flops. It must be high at two clock edges before the fetch edge, and it has no effect in cycles without a fetch.
- R7: After an injection the sequencer spends one cycle each in `ST_SAVE` (save strobe high), `ST_VEC_LO` (vector read at `VEC_ADDR`, default 16'hFFFE) and `ST_VEC_HI` (read at `VEC_ADDR`+1). It then returns to `ST_RUN`. Fetch strobes are ignored while it is busy.
- R8: The return strobe clears the mask on the next edge.
- R9: If the request is still high after the return, it is injected again at the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_req | input | 1 | Asynchronous, level-sensitive interrupt request |
| fetch_en | input | 1 | Opcode-fetch strobe (instruction boundary) |
| mem_data | input | DATA_W | Memory data bus |
| rti_strobe | input | 1 | End-of-handler strobe, clears the mask |
| opcode | output | DATA_W | Opcode register |
| irq_ack | output | 1 | One-cycle interrupt acknowledge |
| irq_masked | output | 1 | Interrupt-disable bit |
| seq_busy | output | 1 | Call sequencer is outside `ST_RUN` |
| save_ctx | output | 1 | Save-return-point strobe (`ST_SAVE`) |
| vec_rd | output | 1 | Vector byte read strobe |
| vec_addr | output | ADDR_W | Vector byte address |

## Verification
The hardest case to reach is a fetch strobe that arrives while the sequencer is busy and a request is pending. It has to be shown that this fetch neither replaces the injected opcode nor causes a second injection. The bench holds the fetch strobe high through every cycle after an injection, with a changing data bus, and watches the opcode and acknowledge across the call. The synchroniser edge is found by raising the request exactly one and exactly two edges before a fetch. The level-retrigger case is covered by issuing the return with the line still high.

// File: rtl/irq_inject_pkg.sv
package irq_inject_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SAVE   = 2'd1,
        ST_VEC_LO = 2'd2,
        ST_VEC_HI = 2'd3
    } seq_state_t;
endpackage

// File: rtl/irq_level_sync.sv
module irq_level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d_async;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/opcode_select_reg.sv
module opcode_select_reg #(
    parameter int              DATA_W     = 8,
    parameter logic [DATA_W-1:0] IRQ_OPCODE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              inject,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] op_q
);
    logic [DATA_W-1:0] op_next;

    always_comb begin
        op_next = inject ? IRQ_OPCODE : bus_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    op_q <= '0;
        else if (load) op_q <= op_next;
    end
endmodule

// File: rtl/irq_call_seq.sv
module irq_call_seq
    import irq_inject_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              save_ctx,
    output logic              vec_rd,
    output logic [ADDR_W-1:0] vec_addr
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (start) state_d = ST_SAVE;
            ST_SAVE:   state_d = ST_VEC_LO;
            ST_VEC_LO: state_d = ST_VEC_HI;
            ST_VEC_HI: state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    always_comb begin
        busy     = 1'b1;
        save_ctx = 1'b0;
        vec_rd   = 1'b0;
        vec_addr = '0;
        unique case (state_q)
            ST_RUN:    busy = 1'b0;
            ST_SAVE:   save_ctx = 1'b1;
            ST_VEC_LO: begin
                vec_rd   = 1'b1;
                vec_addr = VEC_ADDR;
            end
            ST_VEC_HI: begin
                vec_rd   = 1'b1;
                vec_addr = VEC_ADDR + ADDR_W'(1);
            end
            default:   busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_inject_unit.sv
module irq_inject_unit #(
    parameter int                DATA_W      = 8,
    parameter int                ADDR_W      = 16,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] IRQ_OPCODE  = 8'h00,
    parameter logic [ADDR_W-1:0] VEC_ADDR    = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic              fetch_en,
    input  logic [DATA_W-1:0] mem_data,
    input  logic              rti_strobe,
    output logic [DATA_W-1:0] opcode,
    output logic              irq_ack,
    output logic              irq_masked,
    output logic              seq_busy,
    output logic              save_ctx,
    output logic              vec_rd,
    output logic [ADDR_W-1:0] vec_addr
);
    logic irq_seen;
    logic fetch_ok;
    logic take;

    irq_level_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (irq_req),
        .q_sync  (irq_seen)
    );

    assign fetch_ok = fetch_en & ~seq_busy;
    assign take     = fetch_ok & irq_seen & ~irq_masked;

    opcode_select_reg #(.DATA_W(DATA_W), .IRQ_OPCODE(IRQ_OPCODE)) u_opreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fetch_ok),
        .inject   (take),
        .bus_data (mem_data),
        .op_q     (opcode)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_masked <= 1'b1;
            irq_ack    <= 1'b0;
        end else begin
            irq_ack <= take;
            if (take)            irq_masked <= 1'b1;
            else if (rti_strobe) irq_masked <= 1'b0;
        end
    end

    irq_call_seq #(.ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (take),
        .busy     (seq_busy),
        .save_ctx (save_ctx),
        .vec_rd   (vec_rd),
        .vec_addr (vec_addr)
    );
endmodule

// File: rtl/irq_inject_chk.sv
module irq_inject_chk #(
    parameter int                DATA_W     = 8,
    parameter int                ADDR_W     = 16,
    parameter logic [DATA_W-1:0] IRQ_OPCODE = 8'h00,
    parameter logic [ADDR_W-1:0] VEC_ADDR   = 16'hFFFE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_en,
    input logic              rti_strobe,
    input logic [DATA_W-1:0] opcode,
    input logic              irq_ack,
    input logic              irq_masked,
    input logic              seq_busy,
    input logic              save_ctx,
    input logic              vec_rd,
    input logic [ADDR_W-1:0] vec_addr
);
    AST_HOLD_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_en |=> $stable(opcode)); // R2
    AST_ACK_INJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (opcode == IRQ_OPCODE) && irq_masked && save_ctx); // R3
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack); // R4
    AST_NO_ACK_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_masked && !rti_strobe |=> !irq_ack); // R5
    AST_SAVE_TO_VLO: assert property (@(posedge clk) disable iff (!rst_n)
        save_ctx |=> vec_rd && (vec_addr == VEC_ADDR)); // R7
    AST_VLO_TO_VHI: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rd && (vec_addr == VEC_ADDR) |=> vec_rd && (vec_addr == VEC_ADDR + ADDR_W'(1))); // R7
    AST_BUSY_IGNORES_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |=> $stable(opcode)); // R7
    AST_RTI_UNMASKS: assert property (@(posedge clk) disable iff (!rst_n)
        rti_strobe && !irq_ack && !seq_busy && !(fetch_en && !irq_masked) |=> !irq_masked); // R8
endmodule

bind irq_inject_unit irq_inject_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IRQ_OPCODE(IRQ_OPCODE), .VEC_ADDR(VEC_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .rti_strobe(rti_strobe),
    .opcode(opcode), .irq_ack(irq_ack), .irq_masked(irq_masked),
    .seq_busy(seq_busy), .save_ctx(save_ctx), .vec_rd(vec_rd), .vec_addr(vec_addr)
);

// File: tb/tb_irq_inject_unit.sv
module tb_irq_inject_unit;
    localparam logic [7:0]  IRQ_OP = 8'h00;
    localparam logic [15:0] VEC    = 16'hFFFE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic        fetch_en = 1'b0;
    logic [7:0]  mem_data = 8'h00;
    logic        rti_strobe = 1'b0;
    logic [7:0]  opcode;
    logic        irq_ack, irq_masked, seq_busy, save_ctx, vec_rd;
    logic [15:0] vec_addr;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_inject_unit dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .fetch_en(fetch_en),
        .mem_data(mem_data), .rti_strobe(rti_strobe), .opcode(opcode),
        .irq_ack(irq_ack), .irq_masked(irq_masked), .seq_busy(seq_busy),
        .save_ctx(save_ctx), .vec_rd(vec_rd), .vec_addr(vec_addr)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_rti();
        rti_strobe = 1'b1;
        tick();
        rti_strobe = 1'b0;
    endtask

    task automatic check_call_sequence();
        // cycle right after the injecting edge: ST_SAVE
        check("R4 ack", {31'd0, irq_ack}, 1);
        check("R4 mask", {31'd0, irq_masked}, 1);
        check("R7 save", {31'd0, save_ctx}, 1);
        fetch_en = 1'b1; mem_data = 8'h3C;
        tick();
        check("R4 ack one cycle", {31'd0, irq_ack}, 0);
        check("R7 vlo", {15'd0, vec_rd, vec_addr}, {15'd0, 1'b1, VEC});
        check("R7 busy fetch ignored", {24'd0, opcode}, {24'd0, IRQ_OP});
        mem_data = 8'hC3;
        tick();
        check("R7 vhi", {15'd0, vec_rd, vec_addr}, {15'd0, 1'b1, VEC + 16'd1});
        check("R7 busy fetch ignored", {24'd0, opcode}, {24'd0, IRQ_OP});
        fetch_en = 1'b0;
        tick();
        check("R7 back to run", {30'd0, seq_busy, irq_ack}, 0);
        check("R7 opcode held", {24'd0, opcode}, {24'd0, IRQ_OP});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check("R1 opcode", {24'd0, opcode}, 0);
        check("R1 flags", {29'd0, irq_masked, irq_ack, seq_busy}, 32'b100);
        rst_n = 1'b1;
        tick();

        // R2: sweep every data value through the fetch path (masked)
        for (int v = 0; v < 256; v++) begin
            fetch_en = 1'b1; mem_data = 8'(v);
            irq_req = v[0];
            tick();
            check("R2/R5 sweep load", {23'd0, irq_ack, opcode}, {23'd0, 1'b0, 8'(v)});
        end
        fetch_en = 1'b0; mem_data = 8'h77;
        tick(); tick();
        check("R2 hold without fetch", {24'd0, opcode}, 32'hFF);

        // R5: masked, request high and settled
        irq_req = 1'b1; tick(); tick();
        fetch_en = 1'b1; mem_data = 8'h5A; tick(); fetch_en = 1'b0;
        check("R5 masked load", {23'd0, irq_ack, opcode}, 32'h5A);
        irq_req = 1'b0; tick(); tick();

        // R8: return clears mask
        do_rti();
        check("R8 unmasked", {31'd0, irq_masked}, 0);

        // R6: request raised one edge before fetch is not yet seen
        irq_req = 1'b1; fetch_en = 1'b1; mem_data = 8'h11;
        tick();
        mem_data = 8'h12;
        tick();
        check("R6 too late", {23'd0, irq_ack, opcode}, 32'h12);
        // R6: no fetch, no injection
        fetch_en = 1'b0; mem_data = 8'h99;
        tick(); tick(); tick();
        check("R6 no fetch no take", {23'd0, irq_ack, opcode}, 32'h12);

        // R3: fetch with synced, unmasked request
        fetch_en = 1'b1; mem_data = 8'hA5;
        tick();
        fetch_en = 1'b0;
        check("R3 injected", {24'd0, opcode}, {24'd0, IRQ_OP});
        check_call_sequence();

        // R5: inside handler, request still high, masked
        fetch_en = 1'b1; mem_data = 8'h42; tick(); fetch_en = 1'b0;
        check("R5 handler fetch", {23'd0, irq_ack, opcode}, 32'h42);

        // R9: return with request still high, retaken at next fetch
        do_rti();
        fetch_en = 1'b1; mem_data = 8'hE7; tick(); fetch_en = 1'b0;
        check("R9 retaken", {24'd0, opcode}, {24'd0, IRQ_OP});
        check_call_sequence();

        // R8: request dropped, return, fetch loads data
        irq_req = 1'b0; tick(); tick();
        do_rti();
        fetch_en = 1'b1; mem_data = 8'hB2; tick(); fetch_en = 1'b0;
        check("R8 normal after return", {24'd0, irq_masked, irq_ack, 6'd0, opcode} , {24'd0, 8'hB2});

        // R6: request raised exactly two edges before fetch is taken
        irq_req = 1'b1; tick();
        fetch_en = 1'b1; mem_data = 8'h66; tick(); fetch_en = 1'b0;
        check("R6 two edges", {24'd0, opcode}, 32'h66);
        irq_req = 1'b1; fetch_en = 1'b1; mem_data = 8'h67; tick(); fetch_en = 1'b0;
        check("R6 synced take", {24'd0, opcode}, {24'd0, IRQ_OP});
        check_call_sequence();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule